// File: doc/BRIEF.md
# Dual-Slot Edge Capture

This block watches an already synchronized timer pin for a selected kind of edge. On each qualifying edge it takes a snapshot of a free-running counter. The first snapshot goes into slot one and the second into slot two. After two snapshots the block ignores the pin until software re-arms it. A one-cycle event strobe goes to the interrupt status logic. Software chooses whether the strobe follows the first snapshot or the second.

The active edge mode is held in the block and is loaded from `cap_mode_i` in any cycle where `mode_wr_i` is high. The new mode applies from the next cycle. Slot counting is kept by a three-state machine:

- `CS_EMPTY`: no snapshot taken yet.
- `CS_ONE`: one snapshot taken.
- `CS_FULL`: both slots hold a snapshot.

Its transitions are:

- Capture hit: `CS_EMPTY` to `CS_ONE`, then `CS_ONE` to `CS_FULL`.
- Hold: `CS_FULL` stays in `CS_FULL` on further edges.
- Clear: a status clear strobe sends any state back to `CS_EMPTY`.
- Re-arm: a mode write that enables capture while capture was disabled also sends any state back to `CS_EMPTY`.

Clear and re-arm both take priority over a hit in the same cycle.

Top module: `edge_snap_capture`

## Requirements
- R1: After reset both slots read 0, the event strobe is 0, the slot count is zero, the mode is disabled and the remembered pin level is 0.
- R2: Mode encoding is 0 = disabled, 1 = rising (previous 0, now 1), 2 = falling (previous 1, now 0), 3 = either edge. A mode written with `mode_wr_i` applies from the next cycle. With mode 0 no snapshot is taken.
- R3: No snapshot is taken while `pin_is_input_i` is 0.
- R4: The first qualifying edge loads slot one with `cnt_val_i` as sampled at that clock edge. The second loads slot two. The new value is visible right after that clock edge.
- R5: Once both slots are filled, further edges change neither slot and raise no strobe.
- R6: `cap_evt_o` is high for exactly the one cycle after a snapshot. With `sel_second_i` = 0 it follows the first snapshot, and with 1 it follows the second. It is never high at any other time.
- R7: A high on `cap_clr_i` sets the count back to zero, so the next qualifying edge writes slot one again. Slot contents are kept. An edge in the same cycle as the clear is dropped.
- R8: A mode write from disabled to any enabled mode sets the count to zero. A write from one enabled mode to another leaves the count alone.
- R9: The pin level is remembered every cycle, even while capture is disabled. Enabling capture while the pin is already high therefore does not cause a rising capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_lvl_i | input | 1 | Synchronized pin level |
| cnt_val_i | input | CNT_W | Running counter value |
| cap_mode_i | input | 2 | Edge mode to load on a mode write |
| sel_second_i | input | 1 | 0: event after first snapshot, 1: after second |
| pin_is_input_i | input | 1 | Pin direction, 1 = input |
| cap_clr_i | input | 1 | Capture status clear strobe |
| mode_wr_i | input | 1 | Mode write strobe |
| cap1_o | output | CNT_W | Slot one snapshot |
| cap2_o | output | CNT_W | Slot two snapshot |
| cap_evt_o | output | 1 | One-cycle capture event |

## Verification
The properties take for granted that `pin_lvl_i` is already synchronous to `clk`. They also assume that clear and mode write are single-cycle strobes from a register interface. The stimulus changes every input only at the falling clock edge. It pulses each strobe for exactly one cycle. It drives `sel_second_i` only to values that software would hold between clears.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        CM_OFF  = 2'd0,
        CM_RISE = 2'd1,
        CM_FALL = 2'd2,
        CM_BOTH = 2'd3
    } cap_mode_e;

    typedef enum logic [1:0] {
        CS_EMPTY = 2'd0,
        CS_ONE   = 2'd1,
        CS_FULL  = 2'd2
    } cap_state_e;

    localparam int NUM_SLOTS = 2;
endpackage

// File: rtl/cap_edge_qual.sv
module cap_edge_qual
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_lvl,
    input  logic      mode_wr,
    input  logic [1:0] mode_new,
    output logic      edge_hit,
    output logic      rearm,
    output cap_mode_e mode_q
);
    logic pin_prev_q;
    logic rise_w;
    logic fall_w;

    // previous level is tracked every cycle, whatever the mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_prev_q <= 1'b0;
            mode_q     <= CM_OFF;
        end else begin
            pin_prev_q <= pin_lvl;
            if (mode_wr)
                mode_q <= cap_mode_e'(mode_new);
        end
    end

    assign rise_w = !pin_prev_q && pin_lvl;
    assign fall_w = pin_prev_q && !pin_lvl;

    always_comb begin
        unique case (mode_q)
            CM_OFF:  edge_hit = 1'b0;
            CM_RISE: edge_hit = rise_w;
            CM_FALL: edge_hit = fall_w;
            CM_BOTH: edge_hit = rise_w || fall_w;
            default: edge_hit = 1'b0;
        endcase
    end

    assign rearm = mode_wr && (mode_q == CM_OFF) && (mode_new != 2'd0);
endmodule

// File: rtl/cap_slot_fsm.sv
module cap_slot_fsm
    import cap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hit,
    input  logic                 clr,
    input  logic                 rearm,
    input  logic                 sel_second,
    output logic [NUM_SLOTS-1:0] slot_we,
    output logic                 evt,
    output cap_state_e           state_q
);
    cap_state_e state_d;
    logic       evt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CS_EMPTY;
            evt     <= 1'b0;
        end else begin
            state_q <= state_d;
            evt     <= evt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (clr || rearm) begin
            state_d = CS_EMPTY;
        end else if (hit) begin
            unique case (state_q)
                CS_EMPTY: state_d = CS_ONE;
                CS_ONE:   state_d = CS_FULL;
                CS_FULL:  state_d = CS_FULL;
                default:  state_d = CS_EMPTY;
            endcase
        end
    end

    always_comb begin
        slot_we = '0;
        evt_d   = 1'b0;
        if (hit && !clr && !rearm) begin
            unique case (state_q)
                CS_EMPTY: begin
                    slot_we[0] = 1'b1;
                    evt_d      = !sel_second;
                end
                CS_ONE: begin
                    slot_we[1] = 1'b1;
                    evt_d      = sel_second;
                end
                CS_FULL: begin
                    slot_we = '0;
                    evt_d   = 1'b0;
                end
                default: begin
                    slot_we = '0;
                    evt_d   = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
    parameter int W = 32,
    parameter int N = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        we,
    input  logic [W-1:0]        din,
    output logic [N-1:0][W-1:0] slot_q
);
    for (genvar i = 0; i < N; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= '0;
            else if (we[i])
                slot_q[i] <= din;
        end
    end
endmodule

// File: rtl/edge_snap_capture.sv
module edge_snap_capture
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_lvl_i,
    input  logic [CNT_W-1:0] cnt_val_i,
    input  logic [1:0]       cap_mode_i,
    input  logic             sel_second_i,
    input  logic             pin_is_input_i,
    input  logic             cap_clr_i,
    input  logic             mode_wr_i,
    output logic [CNT_W-1:0] cap1_o,
    output logic [CNT_W-1:0] cap2_o,
    output logic             cap_evt_o
);
    logic                           edge_hit;
    logic                           rearm;
    cap_mode_e                      mode_q;
    cap_state_e                     st_q;
    logic [NUM_SLOTS-1:0]           slot_we;
    logic [NUM_SLOTS-1:0][CNT_W-1:0] slots;

    cap_edge_qual u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_lvl  (pin_lvl_i),
        .mode_wr  (mode_wr_i),
        .mode_new (cap_mode_i),
        .edge_hit (edge_hit),
        .rearm    (rearm),
        .mode_q   (mode_q)
    );

    cap_slot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (edge_hit && pin_is_input_i),
        .clr        (cap_clr_i),
        .rearm      (rearm),
        .sel_second (sel_second_i),
        .slot_we    (slot_we),
        .evt        (cap_evt_o),
        .state_q    (st_q)
    );

    cap_store #(.W(CNT_W), .N(NUM_SLOTS)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (slot_we),
        .din    (cnt_val_i),
        .slot_q (slots)
    );

    assign cap1_o = slots[0];
    assign cap2_o = slots[1];
endmodule

// File: rtl/cap_checker.sv
module cap_checker
    import cap_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pin_is_input,
    input logic             cap_clr,
    input logic             cap_evt,
    input cap_state_e       state,
    input cap_mode_e        mode,
    input logic [CNT_W-1:0] cap1,
    input logic [CNT_W-1:0] cap2
);
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CM_OFF) |=> ($stable(cap1) && $stable(cap2))); // R2

    AST_OUTPUT_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_input |=> ($stable(cap1) && $stable(cap2))); // R3

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CS_FULL) |=> ($stable(cap1) && $stable(cap2) && !cap_evt)); // R5

    AST_EVT_AFTER_SNAP: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> (state != CS_EMPTY)); // R6

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        cap_clr |=> (state == CS_EMPTY)); // R7
endmodule

bind edge_snap_capture cap_checker #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_is_input (pin_is_input_i),
    .cap_clr      (cap_clr_i),
    .cap_evt      (cap_evt_o),
    .state        (st_q),
    .mode         (mode_q),
    .cap1         (cap1_o),
    .cap2         (cap2_o)
);

// File: tb/test_edge_snap_capture.sv
module test_edge_snap_capture;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pin = 1'b0;
    logic [W-1:0] cnt = '0;
    logic [1:0]   mode = 2'd0;
    logic         sel = 1'b0;
    logic         inp = 1'b0;
    logic         clr = 1'b0;
    logic         mwr = 1'b0;
    logic [W-1:0] c1;
    logic [W-1:0] c2;
    logic         evt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    edge_snap_capture #(.CNT_W(W)) i_edge_snap_capture (
        .clk(clk), .rst_n(rst_n), .pin_lvl_i(pin), .cnt_val_i(cnt),
        .cap_mode_i(mode), .sel_second_i(sel), .pin_is_input_i(inp),
        .cap_clr_i(clr), .mode_wr_i(mwr), .cap1_o(c1), .cap2_o(c2),
        .cap_evt_o(evt)
    );

    typedef struct packed {
        logic         pin;
        logic [31:0]  cnt;
        logic         inp;
        logic         clr;
        logic         mwr;
        logic [1:0]   mode;
        logic         sel;
        logic         ev;
        logic [31:0]  c1;
        logic [31:0]  c2;
        logic [3:0]   req;
    } vec_t;

    localparam int NV = 25;
    // pin, cnt, inp, clr, mwr, mode, sel | evt, cap1, cap2 | requirement
    localparam vec_t VEC [NV] = '{
        '{1'b0, 32'h10, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 32'h00, 32'h00, 4'd2}, // R2 set rising
        '{1'b1, 32'h11, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h11, 32'h00, 4'd4}, // R4 first slot, R6
        '{1'b0, 32'h12, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h11, 32'h00, 4'd2}, // R2 fall ignored
        '{1'b1, 32'h13, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h11, 32'h13, 4'd4}, // R4 second slot
        '{1'b0, 32'h14, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h11, 32'h13, 4'd5},
        '{1'b1, 32'h15, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h11, 32'h13, 4'd5}, // R5 full
        '{1'b0, 32'h16, 1'b1, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 32'h11, 32'h13, 4'd7}, // R7 clear
        '{1'b1, 32'h20, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h20, 32'h13, 4'd6}, // R6 sel=1 no evt
        '{1'b0, 32'h21, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 32'h20, 32'h13, 4'd8}, // R8 on->on
        '{1'b1, 32'h22, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h20, 32'h13, 4'd2}, // R2 rise ignored
        '{1'b0, 32'h23, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 32'h20, 32'h23, 4'd8}, // R8 count kept
        '{1'b1, 32'h30, 1'b0, 1'b1, 1'b1, 2'd3, 1'b1, 1'b0, 32'h20, 32'h23, 4'd7}, // R7
        '{1'b0, 32'h31, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h20, 32'h23, 4'd3}, // R3 output pin
        '{1'b1, 32'h32, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h32, 32'h23, 4'd2}, // R2 both, rise
        '{1'b0, 32'h33, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 32'h32, 32'h33, 4'd6}, // R6 both, fall
        '{1'b0, 32'h34, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 32'h32, 32'h33, 4'd2}, // R2 off
        '{1'b1, 32'h35, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h32, 32'h33, 4'd2}, // R2 off ignores
        '{1'b1, 32'h36, 1'b1, 1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 32'h32, 32'h33, 4'd8}, // R8 rearm
        '{1'b1, 32'h37, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h32, 32'h33, 4'd9}, // R9 no phantom
        '{1'b0, 32'h38, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h32, 32'h33, 4'd9},
        '{1'b1, 32'h39, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h39, 32'h33, 4'd8}, // R8 slot one again
        '{1'b0, 32'h3A, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0, 32'h39, 32'h33, 4'd7},
        '{1'b1, 32'h3B, 1'b1, 1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 32'h39, 32'h33, 4'd7}, // R7 edge dropped
        '{1'b0, 32'h3C, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h39, 32'h33, 4'd7},
        '{1'b1, 32'h3D, 1'b1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 32'h3D, 32'h33, 4'd6}  // R6 sel=0
    };

    function automatic string req_name(input logic [3:0] r);
        case (r)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "cap1", c1, '0);
        check("R1", "cap2", c2, '0);
        check("R1", "evt", {31'b0, evt}, '0);

        for (int i = 0; i < NV; i++) begin
            pin = VEC[i].pin; cnt = VEC[i].cnt; inp = VEC[i].inp;
            clr = VEC[i].clr; mwr = VEC[i].mwr; mode = VEC[i].mode;
            sel = VEC[i].sel;
            @(negedge clk);
            check(req_name(VEC[i].req), $sformatf("row%0d evt", i), {31'b0, evt}, {31'b0, VEC[i].ev});
            check(req_name(VEC[i].req), $sformatf("row%0d cap1", i), c1, VEC[i].c1);
            check(req_name(VEC[i].req), $sformatf("row%0d cap2", i), c2, VEC[i].c2);
        end
        clr = 1'b0; mwr = 1'b0;

        // R1 mid-run reset clears slots and disables capture
        rst_n = 1'b0; pin = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "cap1 after reset", c1, '0);
        check("R1", "cap2 after reset", c2, '0);
        pin = 1'b1; cnt = 32'h55;
        @(negedge clk);
        check("R1", "mode off after reset", c1, '0);
        check("R1", "no evt after reset", {31'b0, evt}, '0);

        // R4 counter sampled at the edge, full width
        mwr = 1'b1; mode = 2'd2; sel = 1'b0;
        @(negedge clk);
        mwr = 1'b0; pin = 1'b0; cnt = 32'hFFFF_FFFE;
        @(negedge clk);
        cnt = 32'h0;
        check("R4", "wide snapshot", c1, 32'hFFFF_FFFE);
        check("R6", "evt pulse", {31'b0, evt}, 32'h1);
        @(negedge clk);
        check("R6", "evt one cycle", {31'b0, evt}, '0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end
endmodule